// File: doc/BRIEF.md
# Stuck-Low Bus Timeout Monitor

This block guards the shared downstream side of a two-wire bus multiplexer against a line that stays low. Two comparators sit on each of the shared data and clock nodes. For each node they report whether it is below a low threshold and whether it is above a higher threshold. A saturating cycle counter advances while either node is low. It is cleared only once both nodes are clearly high. Between the two thresholds the count holds, which gives the monitor hysteresis.

A 2-bit mode input picks one of three expiry limits, or switches the monitor off. On expiry the block asserts a live timeout status and a buffer-disable output that cuts the upstream-to-downstream buffers. It also sets a sticky status bit and pulls an active-low alert request. The channel switch enables belong to other logic and are left as they are. The live status and the buffer-disable drop as soon as both nodes are high again. The sticky bit stays set until a clear strobe arrives.

Top module: `stuck_low_monitor`

## Requirements
- R1: On a clock edge where the timeout is enabled, at least one node reports below-low, and the two nodes do not both report above-high, the counter advances by one, up to the selected limit.
- R2: On an edge where both nodes report above-high, the counter and the live status clear, whatever the below-low flags say. `buf_off` is therefore low in the next cycle.
- R3: On an edge where neither node reports below-low and the two nodes do not both report above-high, the counter and the live status keep their values. Low time before and after such a gap therefore adds up.
- R4: Mode 2'b01 selects limit LIM_A, 2'b10 selects LIM_B and 2'b11 selects LIM_C (LIM_A >= LIM_B >= LIM_C >= 1). `stuck_live` rises right after the clock edge that completes the limit-th counted low cycle, and not earlier.
- R5: Mode 2'b00 disables the timeout. Each edge in this mode clears the counter and the live status, so no timeout can occur.
- R6: `buf_off` equals `stuck_live`: the upstream-to-downstream buffers are disabled exactly while the live timeout is present.
- R7: `stuck_latched` sets on the edge where `stuck_live` rises and then stays high. It clears on an edge where `latch_clr` is high, unless a new timeout rises on that same edge; in that case set wins.
- R8: `alert_n` is low whenever `stuck_live` or `stuck_latched` is high, and high otherwise.
- R9: The counter saturates at the limit instead of wrapping. Once the live status is set, further low cycles keep it set, including after a change to a longer limit.
- R10: After reset, `stuck_live`, `stuck_latched` and `buf_off` are 0, `alert_n` is 1 and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_below | input | 1 | Data node below the low threshold |
| data_above | input | 1 | Data node above the high threshold |
| clock_below | input | 1 | Clock node below the low threshold |
| clock_above | input | 1 | Clock node above the high threshold |
| tmo_mode | input | 2 | Timeout mode: 00 off, 01 LIM_A, 10 LIM_B, 11 LIM_C |
| latch_clr | input | 1 | Clear strobe for the sticky status |
| stuck_live | output | 1 | Timeout condition currently present |
| stuck_latched | output | 1 | Sticky timeout status |
| alert_n | output | 1 | Active-low alert request |
| buf_off | output | 1 | Disable for the upstream-to-downstream buffers |

## Verification
The bench sweeps every run length from zero to past the longest limit in each mode. An off-by-one in the expiry compare would show up there as the live bit rising one cycle early or late. It splits a run just short of the limit around a gap at every possible point. A design that reset on a gap instead of holding would never expire, and one that treated a single high node as a release would fail the same way. Long low runs check for a wrapping counter that drops the live bit. Clear strobes placed on the expiry edge itself catch a clear that wrongly wins over a new timeout.

// File: rtl/stuck_low_monitor.sv
module stuck_low_monitor #(
  parameter int unsigned LIM_A = 30000,
  parameter int unsigned LIM_B = 15000,
  parameter int unsigned LIM_C = 7500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_below,
  input  logic       data_above,
  input  logic       clock_below,
  input  logic       clock_above,
  input  logic [1:0] tmo_mode,
  input  logic       latch_clr,
  output logic       stuck_live,
  output logic       stuck_latched,
  output logic       alert_n,
  output logic       buf_off
);
  localparam int unsigned CW = $clog2(LIM_A + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          live_q, live_d, latch_q, latch_d;

  wire any_low  = data_below | clock_below;
  wire all_high = data_above & clock_above;
  wire armed    = tmo_mode != 2'b00;

  always_comb begin
    case (tmo_mode)
      2'b01:   lim = CW'(LIM_A);
      2'b10:   lim = CW'(LIM_B);
      2'b11:   lim = CW'(LIM_C);
      default: lim = '0;
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    live_d = live_q;
    if (!armed || all_high) begin
      cnt_d  = '0;
      live_d = 1'b0;
    end else if (any_low) begin
      cnt_d  = (cnt_q >= lim) ? lim : cnt_q + CW'(1);
      live_d = live_q | (cnt_d == lim);
    end
  end

  assign latch_d = (latch_q & ~latch_clr) | (live_d & ~live_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      live_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      live_q  <= live_d;
      latch_q <= latch_d;
    end
  end

  assign stuck_live    = live_q;
  assign buf_off       = live_q;
  assign stuck_latched = latch_q;
  assign alert_n       = ~(live_q | latch_q);

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && any_low && !all_high && cnt_q < lim) |=> cnt_q == $past(cnt_q) + CW'(1));

  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    all_high |=> (!stuck_live && !buf_off && cnt_q == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !any_low && !all_high) |=> ($stable(cnt_q) && $stable(stuck_live)));

  a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!stuck_live && cnt_q == '0));

  a_r7_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck_live) |-> stuck_latched);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck_latched && !latch_clr) |=> stuck_latched);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIM_A));
endmodule

// File: tb/stuck_low_monitor_tb.sv
module stuck_low_monitor_tb_top;
  localparam int LA = 12, LB = 7, LC = 3;

  logic clk = 0, rst_n = 0;
  logic data_below = 0, data_above = 1, clock_below = 0, clock_above = 1;
  logic [1:0] tmo_mode = 2'b01;
  logic latch_clr = 0;
  logic stuck_live, stuck_latched, alert_n, buf_off;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  stuck_low_monitor #(.LIM_A(LA), .LIM_B(LB), .LIM_C(LC)) dut_i (
    .clk(clk), .rst_n(rst_n), .data_below(data_below), .data_above(data_above),
    .clock_below(clock_below), .clock_above(clock_above), .tmo_mode(tmo_mode),
    .latch_clr(latch_clr), .stuck_live(stuck_live), .stuck_latched(stuck_latched),
    .alert_n(alert_n), .buf_off(buf_off));

  task automatic chk(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic dl, logic dh, logic cl, logic ch, logic clr);
    data_below = dl; data_above = dh; clock_below = cl; clock_above = ch;
    latch_clr = clr;
    @(posedge clk); #2;
    latch_clr = 0;
  endtask

  task automatic lows(int n, logic use_clock);
    for (int i = 0; i < n; i++)
      if (use_clock) step(0, 1, 1, 0, 0); else step(1, 0, 0, 1, 0);
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0);
  endtask

  task automatic flush();
    step(0, 1, 0, 1, 1);
  endtask

  function automatic int lim_of(int m);
    return (m == 1) ? LA : (m == 2) ? LB : LC;
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #3;
    chk("R10 live", stuck_live, 0);
    chk("R10 latched", stuck_latched, 0);
    chk("R10 alert_n", alert_n, 1);
    chk("R10 buf_off", buf_off, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;

    for (int m = 1; m <= 3; m++) begin
      tmo_mode = 2'(m);
      for (int n = 0; n <= 15; n++) begin
        flush();
        lows(n, n % 2 == 1);
        chk("R4 live after n lows", stuck_live, n >= lim_of(m));
        chk("R6 buf_off", buf_off, n >= lim_of(m));
        chk("R8 alert_n", alert_n, !(n >= lim_of(m)));
      end
    end

    tmo_mode = 2'b01;
    for (int k = 0; k < LA; k++) begin
      flush();
      lows(k, 0);
      gap(3);
      lows(LA - 1 - k, 1);
      chk("R3 accumulate short", stuck_live, 0);
      lows(1, 0);
      chk("R3 accumulate expire", stuck_live, 1);
      gap(2);
      chk("R3 gap holds live", stuck_live, 1);
    end

    flush();
    tmo_mode = 2'b11;
    lows(LC, 0);
    step(1, 1, 1, 1, 0);
    chk("R2 release wins over low", stuck_live, 0);
    chk("R2 buf_off released", buf_off, 0);
    lows(LC - 1, 0);
    chk("R2 counter restarted", stuck_live, 0);

    flush();
    tmo_mode = 2'b00;
    lows(30, 0);
    chk("R5 mode off no timeout", stuck_live, 0);
    chk("R5 mode off alert_n", alert_n, 1);
    tmo_mode = 2'b01;
    lows(LA - 2, 0);
    tmo_mode = 2'b00;
    lows(1, 0);
    tmo_mode = 2'b01;
    lows(LA - 1, 1);
    chk("R5 mode off cleared count", stuck_live, 0);
    lows(1, 1);
    chk("R1 count resumes to limit", stuck_live, 1);

    flush();
    tmo_mode = 2'b11;
    lows(LC, 0);
    for (int i = 0; i < 40; i++) begin
      lows(1, i % 2 == 0);
      chk("R9 saturated live stays", stuck_live, 1);
    end
    tmo_mode = 2'b01;
    lows(3, 0);
    chk("R9 longer limit keeps live", stuck_live, 1);

    step(0, 1, 0, 1, 0);
    chk("R7 live drops on release", stuck_live, 0);
    chk("R7 latched holds", stuck_latched, 1);
    chk("R8 alert from latched", alert_n, 0);
    gap(4);
    chk("R7 latched still held", stuck_latched, 1);
    step(0, 1, 0, 1, 1);
    chk("R7 clear strobe", stuck_latched, 0);
    chk("R8 alert released", alert_n, 1);

    tmo_mode = 2'b10;
    lows(LB - 1, 0);
    step(1, 0, 0, 1, 1);
    chk("R7 set wins over clear", stuck_latched, 1);
    chk("R4 mode 10 expiry", stuck_live, 1);
    step(1, 0, 0, 1, 1);
    chk("R7 clear during live", stuck_latched, 0);
    chk("R8 alert from live", alert_n, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule